// File: doc/BRIEF.md
# Loopback Code Detector

This block watches a received T1 bit stream for the two in-band loopback control codes. One is a repeating five-bit word with a single one, 00001, that asks for a line loopback. The other is a repeating three-bit word, 001, that asks for release. Both are searched for in parallel. Each search keeps a short history of accepted bits and compares each new bit with the bit that arrived exactly one code period earlier. The comparison does not depend on where the code starts, so no phase search is needed. Each search counts the compares that do not match.

A window timer counts millisecond strobes. At the end of every 48-strobe window, each flag takes its verdict for the window just closed and then holds it until the next window end. A verdict is a pass when no more than fifteen mismatches were counted and at least one accepted bit was a one. The mismatch counters and the one-seen markers are then cleared. When framed operation is selected, any bit tagged by the framing strobe is left out of the history and out of the compare. The bit input is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and a bit is taken on every clock where `in_valid` is high.

Top module: `lpbk_code_det`

## Requirements
- R1: `act_det` is 1 after a window end when, inside that window, no more than 15 accepted bits differed from the accepted bit five places earlier and at least one accepted bit was 1. Otherwise it is 0.
- R2: `deact_det` follows the same rule as R1, with the compare made against the accepted bit three places earlier.
- R3: A window end is the clock on which the 48th `ms_tick` since the previous window end (or since reset) is high. Both flags update only on the clock edge of a window end and hold their value at every other edge. The bit taken on the window-end clock counts toward the next window.
- R4: Exactly 15 mismatches in a window still gives a pass. Exactly 16 mismatches gives a fail.
- R5: The mismatch count saturates at 16. Any larger number of mismatches in a window, such as 40, still gives a fail.
- R6: A window in which every accepted bit is 0 leaves both flags at 0, whatever the mismatch count.
- R7: With `framed_mode` = 1, a bit taken while `in_fbit` = 1 is excluded from both histories and both compares. Extra framing bits inserted into a clean code therefore leave the matching flag set.
- R8: With `framed_mode` = 0, `in_fbit` has no effect.
- R9: A clock with `in_valid` = 0 takes no bit. `in_ready` is always 1.
- R10: After reset both flags are 0, both histories hold zeros, and the window timer starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received bit present |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_bit | input | 1 | Received line bit |
| in_fbit | input | 1 | Marks the current bit as a framing bit |
| framed_mode | input | 1 | 1 = exclude framing-strobed bits |
| ms_tick | input | 1 | One-clock strobe once per millisecond |
| act_det | output | 1 | Loopback-activate code detected in last window |
| deact_det | output | 1 | Loopback-release code detected in last window |

## Verification
A corrupted history, mismatch counter or window timer shows at the ports only at the next window end, up to 48 milliseconds later, as a wrong verdict on one or both flags. A fault that moves the window boundary changes which bits fall into which window, so it shows as a verdict skewed by one window. The bench therefore places its stimulus so that each window has a known mismatch total (exactly 15, exactly 16, and 40). It also compares both flags against a behavioural model on every clock, which catches an update at the wrong edge straight away.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
  localparam int ACT_PERIOD   = 5;
  localparam int DEACT_PERIOD = 3;
  localparam int ERR_TOL      = 15;
  localparam int WIN_MS       = 48;
  localparam int N_CODES      = 2;

  typedef struct packed {
    logic mism;
    logic one;
  } lp_cmp_t;
endpackage

// File: rtl/lpbk_win_timer.sv
module lpbk_win_timer #(
  parameter int WIN_MS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  output logic win_end
);
  localparam int CW = (WIN_MS > 1) ? $clog2(WIN_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_MS - 1);

  logic [CW-1:0] cnt_q;

  assign win_end = ms_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ms_tick) begin
      cnt_q <= win_end ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lpbk_period_match.sv
module lpbk_period_match
  import lpbk_pkg::*;
#(
  parameter int PERIOD  = 5,
  parameter int ERR_TOL = 15,
  localparam int EW     = $clog2(ERR_TOL + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_take,
  input  logic          bit_val,
  input  logic          win_end,
  output logic          det,
  output logic [EW-1:0] err_cnt
);
  localparam logic [EW-1:0] SAT = EW'(ERR_TOL + 1);
  localparam logic [EW-1:0] TOL = EW'(ERR_TOL);

  logic [PERIOD-1:0] hist_q;
  logic [EW-1:0]     err_q, err_base;
  logic              one_q, one_base;
  logic              det_q;
  lp_cmp_t           cmp;

  always_comb begin
    cmp.mism = bit_take && (bit_val != hist_q[PERIOD-1]);
    cmp.one  = bit_take && bit_val;
    err_base = win_end ? '0 : err_q;
    one_base = win_end ? 1'b0 : one_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      err_q  <= '0;
      one_q  <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      if (bit_take) hist_q <= {hist_q[PERIOD-2:0], bit_val};
      if (cmp.mism && (err_base != SAT)) err_q <= err_base + 1'b1;
      else                               err_q <= err_base;
      one_q <= one_base | cmp.one;
      if (win_end) det_q <= (err_q <= TOL) && one_q;
    end
  end

  assign det     = det_q;
  assign err_cnt = err_q;
endmodule

// File: rtl/lpbk_code_det.sv
module lpbk_code_det
  import lpbk_pkg::*;
#(
  parameter int P_ACT   = ACT_PERIOD,
  parameter int P_DEACT = DEACT_PERIOD,
  parameter int E_TOL   = ERR_TOL,
  parameter int W_MS    = WIN_MS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_fbit,
  input  logic framed_mode,
  input  logic ms_tick,
  output logic act_det,
  output logic deact_det
);
  localparam int EW = $clog2(E_TOL + 2);

  logic                          win_end;
  logic                          bit_take;
  logic [N_CODES-1:0]            det_vec;
  logic [N_CODES-1:0][EW-1:0]    err_vec;

  assign in_ready = 1'b1;
  assign bit_take = in_valid && !(framed_mode && in_fbit);

  lpbk_win_timer #(.WIN_MS(W_MS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .win_end (win_end)
  );

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    localparam int PER = (g == 0) ? P_ACT : P_DEACT;
    lpbk_period_match #(.PERIOD(PER), .ERR_TOL(E_TOL)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_take (bit_take),
      .bit_val  (in_bit),
      .win_end  (win_end),
      .det      (det_vec[g]),
      .err_cnt  (err_vec[g])
    );
  end

  assign act_det   = det_vec[0];
  assign deact_det = det_vec[1];
endmodule

// File: rtl/lpbk_code_det_chk.sv
module lpbk_code_det_chk #(
  parameter int E_TOL = 15,
  parameter int W_MS  = 48,
  localparam int EW   = $clog2(E_TOL + 2),
  localparam int CW   = (W_MS > 1) ? $clog2(W_MS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_bit,
  input logic          in_fbit,
  input logic          framed_mode,
  input logic          ms_tick,
  input logic          act_det,
  input logic          deact_det,
  input logic          win_end,
  input logic [EW-1:0] act_err,
  input logic [EW-1:0] deact_err
);
  logic [CW-1:0] tcnt_q;
  logic          seen_one_q;
  logic          chk_end;
  logic          took;

  assign chk_end = ms_tick && (tcnt_q == CW'(W_MS - 1));
  assign took    = in_valid && !(framed_mode && in_fbit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt_q     <= '0;
      seen_one_q <= 1'b0;
    end else begin
      if (ms_tick) tcnt_q <= chk_end ? '0 : tcnt_q + 1'b1;
      seen_one_q <= (chk_end ? 1'b0 : seen_one_q) | (took && in_bit);
    end
  end

  // R3
  win_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end == chk_end);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_end |=> ($stable(act_det) && $stable(deact_det)));

  // R6
  zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_end && !seen_one_q) |=> (!act_det && !deact_det));

  // R4
  act_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_end && (act_err > EW'(E_TOL))) |=> !act_det);

  // R4
  deact_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_end && (deact_err > EW'(E_TOL))) |=> !deact_det);

  // R5
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_err <= EW'(E_TOL + 1)) && (deact_err <= EW'(E_TOL + 1)));

  // R7
  fbit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && framed_mode && in_fbit && !chk_end)
      |=> ($stable(act_err) && $stable(deact_err)));
endmodule

bind lpbk_code_det lpbk_code_det_chk #(.E_TOL(E_TOL), .W_MS(W_MS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_bit      (in_bit),
  .in_fbit     (in_fbit),
  .framed_mode (framed_mode),
  .ms_tick     (ms_tick),
  .act_det     (act_det),
  .deact_det   (deact_det),
  .win_end     (win_end),
  .act_err     (err_vec[0]),
  .deact_err   (err_vec[1])
);

// File: tb/lpbk_code_det_tb_top.sv
`timescale 1ns/1ps
module lpbk_code_det_tb_top;
  localparam int TICK_CYC = 40;
  localparam int WIN_CYC  = TICK_CYC * 48;
  localparam int N_WIN    = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_fbit = 1'b0;
  logic framed_mode = 1'b0, ms_tick = 1'b0;
  logic in_ready, act_det, deact_det;

  lpbk_code_det dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_fbit(in_fbit), .framed_mode(framed_mode),
    .ms_tick(ms_tick), .act_det(act_det), .deact_det(deact_det)
  );

  int checks = 0, fails = 0;
  int c = 0;
  int rcnt = 0;
  int phase = 0;
  bit finished = 0;

  // behavioural reference model
  bit qa[$], qd[$];
  int ea, ed, mcnt;
  bit oa, od, m_act, m_deact;

  task automatic model_reset();
    qa.delete(); qd.delete();
    for (int i = 0; i < 5; i++) qa.push_back(1'b0);
    for (int i = 0; i < 3; i++) qd.push_back(1'b0);
    ea = 0; ed = 0; oa = 0; od = 0; m_act = 0; m_deact = 0; mcnt = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit take, we, ma, md;
      take = in_valid && !(framed_mode && in_fbit);
      we   = ms_tick && (mcnt == 47);
      ma   = take && (in_bit != qa[4]);
      md   = take && (in_bit != qd[2]);
      if (we) begin
        m_act   = (ea <= 15) && oa;
        m_deact = (ed <= 15) && od;
        ea = 0; ed = 0; oa = 0; od = 0;
      end
      ea = ea + int'(ma);
      ed = ed + int'(md);
      if (take && in_bit) begin oa = 1; od = 1; end
      if (take) begin
        qa.push_front(in_bit); void'(qa.pop_back());
        qd.push_front(in_bit); void'(qd.pop_back());
      end
      if (ms_tick) mcnt = (mcnt == 47) ? 0 : mcnt + 1;
      c++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, c);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic bit pat(int j, int p);
    if (j == 1 || j == 8 || j == 9) return (p % 3 == 2);
    if (j == 2) return 1'b0;
    return (p % 5 == 4);
  endfunction

  function automatic int nflips(int j);
    case (j)
      3: return 7;
      4: return 8;
      5: return 20;
      default: return 0;
    endcase
  endfunction

  // expected verdicts per window: act, deact
  function automatic bit exp_act(int j);
    return (j == 0 || j == 3 || j == 6 || j == 7);
  endfunction
  function automatic bit exp_deact(int j);
    return (j == 1 || j == 8 || j == 9);
  endfunction

  function automatic string win_tag(int j);
    case (j)
      0: return "R1 activate code";
      1: return "R2 release code";
      2: return "R6 all zeros";
      3: return "R4 fifteen mismatches";
      4: return "R4 sixteen mismatches";
      5: return "R5 forty mismatches";
      6: return "R8 strobe ignored unframed";
      7: return "R7 framing bits excluded (act)";
      8: return "R7 framing bits excluded (release)";
      default: return "R9 invalid bits ignored";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rcnt < 5) begin
      rcnt++;
      rst_n = 1'b0;
      in_valid = 0; in_bit = 0; in_fbit = 0; framed_mode = 0; ms_tick = 0;
    end else begin
      int j, pos, nf;
      rst_n = 1'b1;
      if (c == 0) begin
        // R10: reset state
        chk(act_det == 1'b0, "R10 act after reset", act_det, 0);
        chk(deact_det == 1'b0, "R10 deact after reset", deact_det, 0);
        chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
      end
      // per-clock model comparison
      chk(act_det == m_act, "R1 model act_det", act_det, m_act);
      chk(deact_det == m_deact, "R2 model deact_det", deact_det, m_deact);
      chk(in_ready == 1'b1, "R9 ready high", in_ready, 1);
      // R3: flags still hold the earlier verdict one clock before the window end
      if (c == 2 * WIN_CYC - 1) begin
        chk(act_det == 1'b1, "R3 act held before end", act_det, 1);
        chk(deact_det == 1'b0, "R3 deact held before end", deact_det, 0);
      end
      if (c > 0 && (c % WIN_CYC) == 0 && (c / WIN_CYC) <= N_WIN) begin
        j = c / WIN_CYC - 1;
        chk(act_det == exp_act(j), {win_tag(j), " act_det"}, act_det, exp_act(j));
        chk(deact_det == exp_deact(j), {win_tag(j), " deact_det"}, deact_det, exp_deact(j));
      end
      if (c >= N_WIN * WIN_CYC + 2) finish_run();

      // drive inputs for the next edge
      j   = (c + 1) / WIN_CYC;
      pos = (c + 1) % WIN_CYC;
      nf  = nflips(j);
      ms_tick     = ((c % TICK_CYC) == TICK_CYC - 1);
      framed_mode = (j == 7 || j == 8);
      in_valid    = 1'b1;
      in_fbit     = 1'b0;
      if (j == 9 && (c % 3 == 0)) begin
        in_valid = 1'b0;
        in_bit   = 1'b1;
      end else if ((j >= 6 && j <= 8) && (c % 193 == 0)) begin
        in_fbit = 1'b1;
        if (j == 6) begin
          in_bit = pat(j, phase);
          phase++;
        end else begin
          in_bit = 1'b1;
        end
      end else begin
        in_bit = pat(j, phase);
        if (pos >= 100 && ((pos - 100) % 80) == 0 && ((pos - 100) / 80) < nf)
          in_bit = ~in_bit;
        phase++;
      end
    end
  end

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", c, N_WIN * WIN_CYC);
      finish_run();
    end
  end
endmodule